// File: doc/BRIEF.md
# External Memory Bus Cycle Sequencer

This block drives the multiplexed external memory bus of a small 8-bit controller core, one oscillator period per clock. A twelve-phase counter divides the clock into machine cycles. At the last phase of each cycle the sequencer can accept one request from the core: a code read, an external data read or an external data write. It runs the following machine cycle as that request, or as an idle cycle when there is none. It produces the address latch strobe, the code read strobe and the data read and write strobes. It places the low address byte and then the data on the shared low port, and drives the high address or the port-2 register value on the high port.

A code cycle fetches two consecutive bytes, one in each half of the machine cycle. A data cycle gives up the second address strobe and both code strobes, so that one long read or write pulse fits in the cycle. For data accesses the high port carries either the upper address byte or, in short (register-indirect, 8-bit) addressing, the value of the port-2 register. A quiet option stops the address strobe in idle cycles. It takes effect only while code is not being fetched from the external bus.

Top module: `xbus_seq`

## Requirements
- R1: While `rst` is high and in the clock after it: `ale`=0, `psen_n`=`rd_n`=`wr_n`=1, `p0_drive`=0, `p2_out`=8'hFF, `rd_valid`=0. Phase 0 of the first machine cycle begins on the first rising edge with `rst` low.
- R2: A machine cycle lasts 12 clocks (phases 0 to 11). `req_ack` is high only in phase 11, when `req_valid` is high. The request taken there (`req_op` 2'b01 code read, 2'b10 data read, 2'b11 data write, 2'b00 none) sets the kind of the next machine cycle. A request held in any other phase waits.
- R3: `ale` is high in phases 0-1 and 6-7 of code cycles and idle cycles, that is two pulses of 2 clocks per 12 clocks. In data cycles it is high only in phases 0-1.
- R4: With `ale_quiet`=1 and `code_ext`=0, `ale` stays low in idle cycles. `ale_quiet` has no effect when `code_ext`=1, and none in code or data cycles.
- R5: In a code cycle `psen_n` is low in phases 3-5 and 9-11. It is never low in data or idle cycles, and at most one of `psen_n`, `rd_n`, `wr_n` is low at a time.
- R6: A code cycle fetches `req_addr` in its first half and `req_addr`+1 (modulo 2^16) in its second. `p0_out` carries the low byte in phases 1-2 and 7-8, and `p2_out` carries the high byte of the matching address through each half.
- R7: A data cycle drives the low address byte on `p0_out` in phases 1-2. `rd_n` or `wr_n` is low in phases 5-10, so it falls 3 clocks after `ale` falls and 4 clocks after the address appears.
- R8: In a data cycle `p2_out` is `req_addr[15:8]` when `req_short`=0 and `p2_sfr` when `req_short`=1. In idle cycles it is `p2_sfr`.
- R9: In a write cycle `p0_out` carries `req_wdata` in phases 4-11, one clock before `wr_n` falls and one clock after it rises. `p0_drive` is low in every phase without address or write data, and always while `psen_n` or `rd_n` is low.
- R10: `p0_in` is sampled at the end of phase 5 (first code byte, `rd_valid` in phase 6 with `rd_second`=0), at the end of phase 11 (second code byte, `rd_valid` in the next phase 0 with `rd_second`=1) and at the end of phase 10 of a data read (`rd_valid` in phase 11, `rd_second`=0). Each `rd_valid` pulse lasts one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock, one phase per period |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core presents a request |
| req_op | input | 2 | Request kind: 01 code, 10 data read, 11 data write |
| req_short | input | 1 | Data access uses 8-bit register-indirect addressing |
| req_addr | input | 16 | Code or data address |
| req_wdata | input | 8 | Data to write |
| req_ack | output | 1 | Request taken at this edge |
| p2_sfr | input | 8 | Current port-2 register value |
| ale_quiet | input | 1 | Suppress the address strobe in idle cycles |
| code_ext | input | 1 | Core executes from external code memory |
| p0_in | input | 8 | Value read back from the low port |
| ale | output | 1 | Address latch strobe, active high |
| psen_n | output | 1 | Code read strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| p0_out | output | 8 | Low port output value |
| p0_drive | output | 1 | Low port output enable |
| p2_out | output | 8 | High port output value |
| rd_valid | output | 1 | Read byte valid, one clock |
| rd_byte | output | 8 | Byte read from the bus |
| rd_second | output | 1 | Byte is the second code byte of its cycle |

## Verification
Two functions meet in phase 11: a data read hands its byte back there, and the next request is taken at the same edge. The end of a code cycle also returns its second byte in the same phase 0 in which the next cycle raises its first address strobe. The bench issues requests back to back in every combination of kinds, across all four settings of the quiet and external-code inputs. At every clock it compares each strobe, both ports and the read-return signals with values worked out from the phase and the current request. A memory model on the bus latches addresses on the falling address strobe, which shows that the two overlapping events do not disturb each other.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  localparam int ADDR_W   = 16;
  localparam int DATA_W   = 8;
  localparam int PHASES   = 12;
  localparam int HALF     = PHASES / 2;
  localparam int SLOTS    = PHASES / HALF;
  localparam int PH_W     = $clog2(PHASES);
  localparam int ALE_W    = 2;          // strobe high at phase 0..ALE_W-1 of a half
  localparam int PSEN_W   = 3;          // low at the last PSEN_W phases of a half
  localparam int STB_START = 5;         // first low phase of read/write strobe
  localparam int STB_W    = 6;

  typedef enum logic [1:0] {
    OP_NONE = 2'b00,
    OP_CODE = 2'b01,
    OP_XRD  = 2'b10,
    OP_XWR  = 2'b11
  } bus_op_e;

  typedef struct packed {
    bus_op_e             op;
    logic                short_ad;
    logic [ADDR_W-1:0]   addr;
    logic [DATA_W-1:0]   wdata;
  } bus_req_t;

  typedef struct packed {
    logic              ale;
    logic              psen_n;
    logic              rd_n;
    logic              wr_n;
    logic              p0_oe;
    logic [DATA_W-1:0] p0;
    logic [DATA_W-1:0] p2;
  } bus_pins_t;

  localparam bus_pins_t PINS_RST = '{ale: 1'b0, psen_n: 1'b1, rd_n: 1'b1,
                                     wr_n: 1'b1, p0_oe: 1'b0, p0: '0, p2: '1};
endpackage

// File: rtl/xbus_phase.sv
module xbus_phase
  import xbus_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  output logic [PH_W-1:0] ph,
  output logic [PH_W-1:0] ph_nxt,
  output logic            at_last
);
  always_comb begin
    at_last = (ph == PH_W'(PHASES - 1));
    ph_nxt  = at_last ? '0 : ph + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) ph <= PH_W'(PHASES - 1);
    else     ph <= ph_nxt;
  end

  // R2: the counter wraps to phase 0 after the last phase
  a_r2_phase_wrap: assert property (@(posedge clk) disable iff (rst)
    at_last |=> (ph == '0));
  a_r2_phase_range: assert property (@(posedge clk) disable iff (rst)
    ph < PH_W'(PHASES));
endmodule

// File: rtl/xbus_req_latch.sv
module xbus_req_latch
  import xbus_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     at_last,
  input  logic     req_valid,
  input  bus_req_t req_in,
  output logic     req_ack,
  output bus_op_e  cur_op,
  output bus_req_t nxt
);
  bus_req_t cur;

  always_comb begin
    req_ack = at_last && req_valid && !rst;
    nxt     = cur;
    if (at_last) nxt = req_valid ? req_in : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) cur <= '0;
    else     cur <= nxt;
  end

  assign cur_op = cur.op;

  // R2: the active request never changes inside a machine cycle
  a_r2_hold_in_cycle: assert property (@(posedge clk) disable iff (rst)
    !at_last |=> $stable(cur));
endmodule

// File: rtl/xbus_decode.sv
module xbus_decode
  import xbus_pkg::*;
(
  input  bus_req_t          req,
  input  logic [PH_W-1:0]   ph,
  input  logic              ale_quiet,
  input  logic              code_ext,
  input  logic [DATA_W-1:0] p2_sfr,
  output bus_pins_t         pins
);
  logic [ADDR_W-1:0] slot_addr [SLOTS];
  logic              half;
  logic [PH_W-1:0]   q;
  logic              is_code, is_data, is_none;
  logic              addr_ph, wdat_ph, strobe_ph;

  // one address per fetch slot: slot g fetches req.addr + g
  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    assign slot_addr[g] = req.addr + ADDR_W'(g);
  end

  always_comb begin
    half      = (ph >= PH_W'(HALF));
    q         = half ? ph - PH_W'(HALF) : ph;
    is_code   = (req.op == OP_CODE);
    is_data   = req.op[1];
    is_none   = (req.op == OP_NONE);
    addr_ph   = !is_none && !(is_data && half) &&
                (q == PH_W'(ALE_W - 1) || q == PH_W'(ALE_W));
    wdat_ph   = (req.op == OP_XWR) && (ph >= PH_W'(STB_START - 1));
    strobe_ph = (ph >= PH_W'(STB_START)) && (ph < PH_W'(STB_START + STB_W));

    pins.ale    = (q < PH_W'(ALE_W)) && !(is_data && half) &&
                  !(is_none && ale_quiet && !code_ext);
    pins.psen_n = !(is_code && q >= PH_W'(HALF - PSEN_W));
    pins.rd_n   = !((req.op == OP_XRD) && strobe_ph);
    pins.wr_n   = !((req.op == OP_XWR) && strobe_ph);
    pins.p0_oe  = addr_ph || wdat_ph;
    if (addr_ph)      pins.p0 = slot_addr[half][DATA_W-1:0];
    else if (wdat_ph) pins.p0 = req.wdata;
    else              pins.p0 = '0;
    if (is_code)                      pins.p2 = slot_addr[half][ADDR_W-1 -: DATA_W];
    else if (is_data && !req.short_ad) pins.p2 = req.addr[ADDR_W-1 -: DATA_W];
    else                              pins.p2 = p2_sfr;
  end
endmodule

// File: rtl/xbus_capture.sv
module xbus_capture
  import xbus_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  bus_op_e           cur_op,
  input  logic [PH_W-1:0]   ph,
  input  logic [DATA_W-1:0] p0_in,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_byte,
  output logic              rd_second
);
  logic take_c0, take_c1, take_d;

  always_comb begin
    take_c0 = (cur_op == OP_CODE) && (ph == PH_W'(HALF - 1));
    take_c1 = (cur_op == OP_CODE) && (ph == PH_W'(PHASES - 1));
    take_d  = (cur_op == OP_XRD)  && (ph == PH_W'(STB_START + STB_W - 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid  <= 1'b0;
      rd_byte   <= '0;
      rd_second <= 1'b0;
    end else begin
      rd_valid <= take_c0 || take_c1 || take_d;
      if (take_c0 || take_c1 || take_d) begin
        rd_byte   <= p0_in;
        rd_second <= take_c1;
      end
    end
  end

  // R10: a returned byte is a single-clock pulse
  a_r10_valid_pulse: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic              req_short,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ack,
  input  logic [DATA_W-1:0] p2_sfr,
  input  logic              ale_quiet,
  input  logic              code_ext,
  input  logic [DATA_W-1:0] p0_in,
  output logic              ale,
  output logic              psen_n,
  output logic              rd_n,
  output logic              wr_n,
  output logic [DATA_W-1:0] p0_out,
  output logic              p0_drive,
  output logic [DATA_W-1:0] p2_out,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_byte,
  output logic              rd_second
);
  logic [PH_W-1:0] ph, ph_nxt;
  logic            at_last;
  bus_req_t        req_in, nxt;
  bus_op_e         cur_op;
  bus_pins_t       pins_d, pins_q;

  assign req_in = '{op: bus_op_e'(req_op), short_ad: req_short,
                    addr: req_addr, wdata: req_wdata};

  xbus_phase u_phase (
    .clk(clk), .rst(rst), .ph(ph), .ph_nxt(ph_nxt), .at_last(at_last));

  xbus_req_latch u_req (
    .clk(clk), .rst(rst), .at_last(at_last), .req_valid(req_valid),
    .req_in(req_in), .req_ack(req_ack), .cur_op(cur_op), .nxt(nxt));

  // decode the phase about to start so every pin leaves a flop
  xbus_decode u_dec (
    .req(nxt), .ph(ph_nxt), .ale_quiet(ale_quiet), .code_ext(code_ext),
    .p2_sfr(p2_sfr), .pins(pins_d));

  always_ff @(posedge clk) begin
    if (rst) pins_q <= PINS_RST;
    else     pins_q <= pins_d;
  end

  assign ale      = pins_q.ale;
  assign psen_n   = pins_q.psen_n;
  assign rd_n     = pins_q.rd_n;
  assign wr_n     = pins_q.wr_n;
  assign p0_drive = pins_q.p0_oe;
  assign p0_out   = pins_q.p0;
  assign p2_out   = pins_q.p2;

  xbus_capture u_cap (
    .clk(clk), .rst(rst), .cur_op(cur_op), .ph(ph), .p0_in(p0_in),
    .rd_valid(rd_valid), .rd_byte(rd_byte), .rd_second(rd_second));

  // R3: every address strobe is two clocks wide
  a_r3_ale_width: assert property (@(posedge clk) disable iff (rst)
    $rose(ale) |=> ale ##1 !ale);
  // R5: every code strobe is three clocks wide
  a_r5_psen_width: assert property (@(posedge clk) disable iff (rst)
    $fell(psen_n) |=> !psen_n ##1 !psen_n ##1 psen_n);
  // R5: never two read/write strobes at once
  a_r5_one_strobe: assert property (@(posedge clk) disable iff (rst)
    $countones({~psen_n, ~rd_n, ~wr_n}) <= 1);
  // R7: data strobe falls three clocks after the address strobe falls
  a_r7_strobe_after_ale: assert property (@(posedge clk) disable iff (rst)
    $fell(rd_n & wr_n) |-> ($past(ale, 4) && !$past(ale, 3)));
  // R9: write data is already stable when the write strobe falls
  a_r9_wdata_setup: assert property (@(posedge clk) disable iff (rst)
    $fell(wr_n) |-> (p0_drive && $past(p0_drive) && $stable(p0_out)));
  // R9: no drive on the low port while memory may drive it
  a_r9_no_contention: assert property (@(posedge clk) disable iff (rst)
    (!psen_n || !rd_n) |-> !p0_drive);
endmodule

// File: tb/test_xbus_seq.sv
`timescale 1ns/1ps
module test_xbus_seq;
  localparam logic [1:0] K_NONE = 2'b00, K_CODE = 2'b01, K_RD = 2'b10, K_WR = 2'b11;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [1:0] req_op = K_NONE;
  logic req_short = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic req_ack;
  logic [7:0] p2_sfr = 8'h00;
  logic ale_quiet = 1'b0, code_ext = 1'b0;
  logic [7:0] p0_in;
  logic ale, psen_n, rd_n, wr_n, p0_drive, rd_valid, rd_second;
  logic [7:0] p0_out, p2_out, rd_byte;

  int n_tests = 0, n_fail = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  xbus_seq i_xbus_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_short(req_short), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_ack(req_ack), .p2_sfr(p2_sfr), .ale_quiet(ale_quiet),
    .code_ext(code_ext), .p0_in(p0_in), .ale(ale), .psen_n(psen_n),
    .rd_n(rd_n), .wr_n(wr_n), .p0_out(p0_out), .p0_drive(p0_drive),
    .p2_out(p2_out), .rd_valid(rd_valid), .rd_byte(rd_byte),
    .rd_second(rd_second));

  function automatic logic [7:0] code_at(logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h3C;
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h (time %0t)", tag, act, exp, $time);
    end
  endtask

  // external memory model
  logic [7:0] xm [256];
  logic [7:0] sx [256];
  logic [7:0] lat = 8'h00;
  initial for (int i = 0; i < 256; i++) begin
    xm[i] = 8'(i * 7 + 1);
    sx[i] = 8'(i * 7 + 1);
  end
  always @(negedge ale) lat = p0_out;
  always @(posedge wr_n) if (!rst) xm[lat] = p0_out;
  always_comb begin
    if (!psen_n)    p0_in = code_at({p2_out, lat});
    else if (!rd_n) p0_in = xm[lat];
    else            p0_in = 8'hFF;
  end

  // bench view of phase and active request
  int bph = 11;
  logic [1:0] c_op = K_NONE;
  logic c_short = 1'b0;
  logic [15:0] c_addr = '0;
  logic [7:0] c_wd = '0;
  logic e_valid = 1'b0, e_second = 1'b0;
  logic [7:0] e_byte = '0;

  always @(posedge clk) begin
    if (rst) begin
      bph = 11; c_op = K_NONE; e_valid = 1'b0;
    end else begin
      e_valid = 1'b0;
      if (c_op == K_CODE && bph == 5) begin
        e_valid = 1'b1; e_second = 1'b0; e_byte = code_at(c_addr);
      end
      if (c_op == K_CODE && bph == 11) begin
        e_valid = 1'b1; e_second = 1'b1; e_byte = code_at(c_addr + 16'd1);
      end
      if (c_op == K_RD && bph == 10) begin
        e_valid = 1'b1; e_second = 1'b0; e_byte = sx[c_addr[7:0]];
      end
      if (bph == 11) begin
        c_op = req_valid ? req_op : K_NONE;
        c_short = req_short; c_addr = req_addr; c_wd = req_wdata;
        if (req_valid && req_op == K_WR) sx[req_addr[7:0]] = req_wdata;
      end
      bph = (bph == 11) ? 0 : bph + 1;
    end
  end

  // per-clock comparison of every output
  always @(negedge clk) begin
    if (!rst) begin
      automatic logic eh = (bph >= 6);
      automatic int q = eh ? bph - 6 : bph;
      automatic logic is_c = (c_op == K_CODE), is_d = c_op[1], is_n = (c_op == K_NONE);
      automatic logic [15:0] sa = (is_c && eh) ? c_addr + 16'd1 : c_addr;
      automatic logic a_ph = !is_n && !(is_d && eh) && (q == 1 || q == 2);
      automatic logic w_ph = (c_op == K_WR) && bph >= 4;
      automatic logic e_ale = (q < 2) && !(is_d && eh) && !(is_n && ale_quiet && !code_ext);
      automatic logic [7:0] e_p2 = is_c ? sa[15:8] : (is_d && !c_short) ? c_addr[15:8] : p2_sfr;
      chk(is_n ? "R4 ale idle" : "R3 ale", 16'(ale), 16'(e_ale));
      chk("R5 psen_n", 16'(psen_n), 16'(!(is_c && q >= 3)));
      chk("R7 rd_n", 16'(rd_n), 16'(!(c_op == K_RD && bph >= 5 && bph <= 10)));
      chk("R7 wr_n", 16'(wr_n), 16'(!(c_op == K_WR && bph >= 5 && bph <= 10)));
      chk("R9 p0_drive", 16'(p0_drive), 16'(a_ph || w_ph));
      if (a_ph) chk(is_c ? "R6 p0 code address" : "R7 p0 data address", 16'(p0_out), 16'(sa[7:0]));
      else if (w_ph) chk("R9 p0 write data", 16'(p0_out), 16'(c_wd));
      chk(is_c ? "R6 p2 code address" : "R8 p2", 16'(p2_out), 16'(e_p2));
      chk("R10 rd_valid", 16'(rd_valid), 16'(e_valid));
      if (e_valid) begin
        chk("R10 rd_byte", 16'(rd_byte), 16'(e_byte));
        chk("R10 rd_second", 16'(rd_second), 16'(e_second));
      end
    end
  end

  task automatic issue(logic [1:0] op, logic [15:0] a, logic sh, logic [7:0] wd);
    do @(negedge clk); while (bph != 11);
    #1;
    req_valid = 1'b1; req_op = op; req_addr = a; req_short = sh; req_wdata = wd;
    #1 chk("R2 ack in phase 11", 16'(req_ack), 16'd1);
    @(negedge clk); #1;
    req_valid = 1'b0; req_op = K_NONE;
  endtask

  task automatic set_cfg(logic qt, logic ext, logic [7:0] p2v);
    do @(negedge clk); while (bph != 11);
    #1; ale_quiet = qt; code_ext = ext; p2_sfr = p2v;
  endtask

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 ale reset", 16'(ale), 16'd0);
    chk("R1 psen_n reset", 16'(psen_n), 16'd1);
    chk("R1 rd_n reset", 16'(rd_n), 16'd1);
    chk("R1 wr_n reset", 16'(wr_n), 16'd1);
    chk("R1 p0_drive reset", 16'(p0_drive), 16'd0);
    chk("R1 p2_out reset", 16'(p2_out), 16'hFF);
    chk("R1 rd_valid reset", 16'(rd_valid), 16'd0);
    #1 rst = 1'b0;
    @(negedge clk);
    chk("R1 first phase ale", 16'(ale), 16'd1);

    // R2: request raised mid-cycle waits for phase 11
    do @(negedge clk); while (bph != 3);
    #1; req_valid = 1'b1; req_op = K_CODE; req_addr = 16'h4321;
    while (bph != 11) begin
      #1 chk("R2 no ack before phase 11", 16'(req_ack), 16'd0);
      @(negedge clk);
    end
    #1 chk("R2 ack in phase 11", 16'(req_ack), 16'd1);
    @(negedge clk); #1; req_valid = 1'b0; req_op = K_NONE;

    for (int cfg = 0; cfg < 4; cfg++) begin
      set_cfg(cfg[0], cfg[1], 8'(8'h90 + cfg));
      issue(K_NONE, 16'h0000, 1'b0, 8'h00);
      issue(K_CODE, 16'h00FF, 1'b0, 8'h00);
      issue(K_CODE, 16'hFFFF, 1'b0, 8'h00);
      issue(K_WR, {8'(cfg), 8'h5A}, 1'b0, 8'(8'hC0 + cfg));
      issue(K_RD, {8'(cfg), 8'h5A}, 1'b0, 8'h00);
      issue(K_WR, 16'h1233, 1'b1, 8'(8'h0F ^ cfg));
      issue(K_CODE, 16'hA5C3, 1'b0, 8'h00);
      issue(K_RD, 16'h7733, 1'b1, 8'h00);
      issue(K_RD, 16'hBEEF, 1'b0, 8'h00);
      issue(K_CODE, 16'h1234, 1'b0, 8'h00);
      issue(K_WR, 16'h8001, 1'b0, 8'hFF);
      issue(K_WR, 16'h8002, 1'b1, 8'h00);
      issue(K_RD, 16'h0001, 1'b0, 8'h00);
      issue(K_RD, 16'h0002, 1'b1, 8'h00);
    end
    repeat (30) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule